// File: doc/BRIEF.md
# Indirect Fuse Byte Reader

This block copies a run of bytes out of a fuse array that sits behind a narrow register window on a slow side-bus. The fuse array cannot be addressed directly. For every byte the block programs the window, waits until the array reports the byte is ready, and then reads it from a data register. The side-bus is modelled as a simple request/acknowledge register port: one transaction at a time, with per-bit write masks and an error flag on completion. The serial layer that carries these transactions is outside the block.

Firmware or a boot sequencer pulses `start` with a first fuse address and a byte count. The block then walks the addresses in ascending order and emits each byte as a one-cycle strobe tagged with its address. It finishes with a `done` pulse and a status code. A bus error on any programming write or on the data read ends the run at once. So does a ready poll that stays unsuccessful past a cycle budget (about 10 ms at the default settings). In both cases the status records the cause of the first failure.

Top module: `fuse_side_reader`

## Requirements
- R1: After reset the block is idle. `busy`, `sb_req`, `done` and `byte_valid` are 0, and `status` is 0 (OK).
- R2: For each byte the block issues four masked writes in a fixed order. The first writes 0x40 to the control register with mask 0xFF. The second writes address bits [7:0] to the low-address register with mask 0xFF. The third writes the address shifted right by 8 to the control register with mask `HI_MASK`. The fourth writes 0 to the control register with mask `MODE_MASK`.
- R3: After the fourth write, the block reads the control register repeatedly. It stops only when a read completes without `sb_err` and with `sb_rdata[RDY_BIT]` set. A poll that returns `sb_err` counts as not ready, even if the ready bit is set.
- R4: After a successful poll, the block reads the data register once. The returned byte appears on `byte_data` together with its address on `byte_addr`, during a one-cycle `byte_valid` pulse.
- R5: A run with count N > 0 produces exactly N bytes, for addresses start to start+N-1 in ascending order. It ends with a one-cycle `done` pulse and status 0.
- R6: A request holds `sb_we`, `sb_addr`, `sb_wdata` and `sb_wmask` stable until `sb_ack`. At most one transaction is outstanding.
- R7: If `sb_err` is returned on any write or on the data read, the run ends. The block pulses `done`, sets status 1 (bus error) and issues no further requests.
- R8: If the ready poll has not succeeded after `TIMEOUT_CYC` cycles, the next unsuccessful poll completion ends the run. The block pulses `done` and sets status 2 (timeout).
- R9: A start with count 0 produces a `done` pulse on the next cycle with status 0, and no bus request.
- R10: A `start` pulse while `busy` is high is ignored. The running job's addresses and byte count do not change.
- R11: `status` holds its value after `done` until the next accepted start, which clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken only when idle) |
| start_addr | input | ADDR_W | First fuse address |
| count | input | CNT_W | Number of bytes to read |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 2 | 0 OK, 1 bus error, 2 timeout |
| byte_valid | output | 1 | Byte strobe |
| byte_data | output | 8 | Fuse byte |
| byte_addr | output | ADDR_W | Address of the byte |
| sb_req | output | 1 | Side-bus request |
| sb_we | output | 1 | 1 write, 0 read |
| sb_addr | output | REG_AW | Register address |
| sb_wdata | output | 8 | Write data |
| sb_wmask | output | 8 | Per-bit write enable |
| sb_ack | input | 1 | Transaction complete |
| sb_rdata | input | 8 | Read data, valid with ack |
| sb_err | input | 1 | Transaction failed, valid with ack |

## Verification
The bench builds the block with an 11-bit fuse address and a high-address mask of 0x07. Runs can therefore cross the 0xFF/0x100 boundary and reach the top address 0x7FF, which exercises the third write's value. The ready bit sits at bit 7 and the mode mask is 0x30. The poll timeout is cut to 48 cycles, so a poll that never becomes ready ends within a few dozen cycles. This allows the timeout latency to be measured against the budget. Poll errors that still carry the ready bit are injected at random.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_CTRL,
        ST_WR_LOW,
        ST_WR_HIGH,
        ST_WR_MODE,
        ST_POLL,
        ST_READ
    } fsr_state_e;

    typedef enum logic [1:0] {
        FSR_OK      = 2'd0,
        FSR_BUS_ERR = 2'd1,
        FSR_TIMEOUT = 2'd2
    } fsr_status_e;

    localparam logic [7:0] FSR_ARM_VALUE = 8'h40;
    localparam logic [7:0] FSR_ALL_BITS  = 8'hFF;

    typedef struct packed {
        logic       req;
        logic       we;
        logic [1:0] target;   // 0 control, 1 low address, 2 data
        logic [7:0] wdata;
        logic [7:0] wmask;
    } fsr_op_t;

    function automatic fsr_state_e fsr_next_write(fsr_state_e s);
        case (s)
            ST_WR_CTRL: return ST_WR_LOW;
            ST_WR_LOW:  return ST_WR_HIGH;
            ST_WR_HIGH: return ST_WR_MODE;
            default:    return ST_POLL;
        endcase
    endfunction

    function automatic logic fsr_is_write(fsr_state_e s);
        return (s == ST_WR_CTRL) || (s == ST_WR_LOW) ||
               (s == ST_WR_HIGH) || (s == ST_WR_MODE);
    endfunction

endpackage

// File: rtl/fsr_op_gen.sv
module fsr_op_gen
    import fsr_pkg::*;
#(
    parameter int         ADDR_W    = 11,
    parameter int         REG_AW    = 8,
    parameter logic [7:0] CTRL_REG  = 8'h10,
    parameter logic [7:0] LOW_REG   = 8'h11,
    parameter logic [7:0] DATA_REG  = 8'h12,
    parameter logic [7:0] HI_MASK   = 8'h07,
    parameter logic [7:0] MODE_MASK = 8'h30
) (
    input  fsr_state_e          state,
    input  logic [ADDR_W-1:0]   addr,
    output logic                req,
    output logic                we,
    output logic [REG_AW-1:0]   reg_addr,
    output logic [7:0]          wdata,
    output logic [7:0]          wmask
);
    logic [7:0] high_bits;
    fsr_op_t    op;

    generate
        if (ADDR_W > 8) begin : g_high
            localparam int HW = (ADDR_W - 8 > 8) ? 8 : ADDR_W - 8;
            assign high_bits = 8'(addr[8 +: HW]);
        end else begin : g_nohigh
            assign high_bits = 8'h00;
        end
    endgenerate

    always_comb begin
        op = '0;
        case (state)
            ST_WR_CTRL: op = '{req: 1'b1, we: 1'b1, target: 2'd0,
                               wdata: FSR_ARM_VALUE, wmask: FSR_ALL_BITS};
            ST_WR_LOW:  op = '{req: 1'b1, we: 1'b1, target: 2'd1,
                               wdata: addr[7:0], wmask: FSR_ALL_BITS};
            ST_WR_HIGH: op = '{req: 1'b1, we: 1'b1, target: 2'd0,
                               wdata: high_bits, wmask: HI_MASK};
            ST_WR_MODE: op = '{req: 1'b1, we: 1'b1, target: 2'd0,
                               wdata: 8'h00, wmask: MODE_MASK};
            ST_POLL:    op = '{req: 1'b1, we: 1'b0, target: 2'd0,
                               wdata: 8'h00, wmask: 8'h00};
            ST_READ:    op = '{req: 1'b1, we: 1'b0, target: 2'd2,
                               wdata: 8'h00, wmask: 8'h00};
            default:    op = '0;
        endcase
    end

    always_comb begin
        req   = op.req;
        we    = op.we;
        wdata = op.wdata;
        wmask = op.wmask;
        case (op.target)
            2'd1:    reg_addr = REG_AW'(LOW_REG);
            2'd2:    reg_addr = REG_AW'(DATA_REG);
            default: reg_addr = REG_AW'(CTRL_REG);
        endcase
    end

endmodule

// File: rtl/fsr_poll_timer.sv
module fsr_poll_timer #(
    parameter int TIMEOUT_CYC = 2_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYC);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == LIMIT);

endmodule

// File: rtl/fsr_walker.sv
module fsr_walker
    import fsr_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int CNT_W   = 8,
    parameter int RDY_BIT = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic [CNT_W-1:0]    count,
    input  logic                ack,
    input  logic                err,
    input  logic [7:0]          rdata,
    input  logic                timer_expired,
    output fsr_state_e          state,
    output logic [ADDR_W-1:0]   cur_addr,
    output logic                done,
    output fsr_status_e         status,
    output logic                byte_valid,
    output logic [7:0]          byte_data,
    output logic [ADDR_W-1:0]   byte_addr
);
    logic [CNT_W-1:0] left;
    logic             poll_ok;

    assign poll_ok = !err && rdata[RDY_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur_addr   <= '0;
            left       <= '0;
            done       <= 1'b0;
            status     <= FSR_OK;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            byte_addr  <= '0;
        end else begin
            done       <= 1'b0;
            byte_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        status <= FSR_OK;
                        if (count == '0) begin
                            done <= 1'b1;
                        end else begin
                            cur_addr <= start_addr;
                            left     <= count;
                            state    <= ST_WR_CTRL;
                        end
                    end
                end
                ST_POLL: begin
                    if (ack) begin
                        if (poll_ok) begin
                            state <= ST_READ;
                        end else if (timer_expired) begin
                            status <= FSR_TIMEOUT;
                            done   <= 1'b1;
                            state  <= ST_IDLE;
                        end
                    end
                end
                ST_READ: begin
                    if (ack) begin
                        if (err) begin
                            status <= FSR_BUS_ERR;
                            done   <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            byte_valid <= 1'b1;
                            byte_data  <= rdata;
                            byte_addr  <= cur_addr;
                            if (left == CNT_W'(1)) begin
                                done  <= 1'b1;
                                state <= ST_IDLE;
                            end else begin
                                left     <= left - 1'b1;
                                cur_addr <= cur_addr + 1'b1;
                                state    <= ST_WR_CTRL;
                            end
                        end
                    end
                end
                default: begin
                    if (fsr_is_write(state) && ack) begin
                        if (err) begin
                            status <= FSR_BUS_ERR;
                            done   <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            state <= fsr_next_write(state);
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/fuse_side_reader.sv
module fuse_side_reader
    import fsr_pkg::*;
#(
    parameter int         ADDR_W      = 11,
    parameter int         CNT_W       = 8,
    parameter int         REG_AW      = 8,
    parameter logic [7:0] CTRL_REG    = 8'h10,
    parameter logic [7:0] LOW_REG     = 8'h11,
    parameter logic [7:0] DATA_REG    = 8'h12,
    parameter int         RDY_BIT     = 7,
    parameter logic [7:0] HI_MASK     = 8'h07,
    parameter logic [7:0] MODE_MASK   = 8'h30,
    parameter int         TIMEOUT_CYC = 2_500_000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic [CNT_W-1:0]    count,
    output logic                busy,
    output logic                done,
    output logic [1:0]          status,
    output logic                byte_valid,
    output logic [7:0]          byte_data,
    output logic [ADDR_W-1:0]   byte_addr,
    output logic                sb_req,
    output logic                sb_we,
    output logic [REG_AW-1:0]   sb_addr,
    output logic [7:0]          sb_wdata,
    output logic [7:0]          sb_wmask,
    input  logic                sb_ack,
    input  logic [7:0]          sb_rdata,
    input  logic                sb_err
);
    fsr_state_e        state;
    fsr_status_e       st_code;
    logic [ADDR_W-1:0] cur_addr;
    logic              expired;

    fsr_walker #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .RDY_BIT(RDY_BIT)
    ) u_walk (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .start_addr   (start_addr),
        .count        (count),
        .ack          (sb_ack),
        .err          (sb_err),
        .rdata        (sb_rdata),
        .timer_expired(expired),
        .state        (state),
        .cur_addr     (cur_addr),
        .done         (done),
        .status       (st_code),
        .byte_valid   (byte_valid),
        .byte_data    (byte_data),
        .byte_addr    (byte_addr)
    );

    fsr_poll_timer #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state == ST_POLL),
        .expired(expired)
    );

    fsr_op_gen #(
        .ADDR_W   (ADDR_W),
        .REG_AW   (REG_AW),
        .CTRL_REG (CTRL_REG),
        .LOW_REG  (LOW_REG),
        .DATA_REG (DATA_REG),
        .HI_MASK  (HI_MASK),
        .MODE_MASK(MODE_MASK)
    ) u_ops (
        .state   (state),
        .addr    (cur_addr),
        .req     (sb_req),
        .we      (sb_we),
        .reg_addr(sb_addr),
        .wdata   (sb_wdata),
        .wmask   (sb_wmask)
    );

    assign busy   = (state != ST_IDLE);
    assign status = st_code;

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
    parameter int CNT_W  = 8,
    parameter int REG_AW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [CNT_W-1:0]  count,
    input logic              busy,
    input logic              done,
    input logic              byte_valid,
    input logic              sb_req,
    input logic              sb_we,
    input logic [REG_AW-1:0] sb_addr,
    input logic [7:0]        sb_wdata,
    input logic [7:0]        sb_wmask,
    input logic              sb_ack
);
    // R6: request fields stay put until acknowledged
    a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
        (sb_req && !sb_ack) |=> (sb_req && $stable(sb_we) && $stable(sb_addr) &&
                                 $stable(sb_wdata) && $stable(sb_wmask)));

    // R7: nothing on the bus once the run has ended
    a_r7_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !sb_req);

    // R5: end-of-run strobe lasts one cycle
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: byte strobe lasts one cycle
    a_r4_byte_pulse: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    // R9: zero-length run finishes at once without the bus
    a_r9_zero_count: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && count == '0) |=> (done && !busy && !sb_req));

    // R10: a run only begins from an idle start
    a_r10_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

endmodule

bind fuse_side_reader fsr_checker #(
    .CNT_W (CNT_W),
    .REG_AW(REG_AW)
) u_fsr_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .count     (count),
    .busy      (busy),
    .done      (done),
    .byte_valid(byte_valid),
    .sb_req    (sb_req),
    .sb_we     (sb_we),
    .sb_addr   (sb_addr),
    .sb_wdata  (sb_wdata),
    .sb_wmask  (sb_wmask),
    .sb_ack    (sb_ack)
);

// File: tb/fuse_side_reader_test.sv
module fuse_side_reader_test;
    localparam int         ADDR_W  = 11;
    localparam int         CNT_W   = 8;
    localparam int         REG_AW  = 8;
    localparam logic [7:0] CTRL_R  = 8'h10;
    localparam logic [7:0] LOW_R   = 8'h11;
    localparam logic [7:0] DATA_R  = 8'h12;
    localparam int         RDY     = 7;
    localparam logic [7:0] HIM     = 8'h07;
    localparam logic [7:0] MODEM   = 8'h30;
    localparam int         TMO     = 48;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [CNT_W-1:0]  count = '0;
    logic busy, done, byte_valid, sb_req, sb_we;
    logic [1:0] status;
    logic [7:0] byte_data, sb_wdata, sb_wmask;
    logic [ADDR_W-1:0] byte_addr;
    logic [REG_AW-1:0] sb_addr;
    logic sb_ack = 1'b0, sb_err = 1'b0;
    logic [7:0] sb_rdata = '0;

    always #2 clk = ~clk;   // 250 MHz

    fuse_side_reader #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_AW(REG_AW),
        .CTRL_REG(CTRL_R), .LOW_REG(LOW_R), .DATA_REG(DATA_R),
        .RDY_BIT(RDY), .HI_MASK(HIM), .MODE_MASK(MODEM), .TIMEOUT_CYC(TMO)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .count(count), .busy(busy), .done(done), .status(status),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_addr(byte_addr),
        .sb_req(sb_req), .sb_we(sb_we), .sb_addr(sb_addr),
        .sb_wdata(sb_wdata), .sb_wmask(sb_wmask),
        .sb_ack(sb_ack), .sb_rdata(sb_rdata), .sb_err(sb_err)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // responder / monitor state
    int step = 0;
    int lat = 0;
    int rdy_cnt = 0;
    int never_ready = 0;
    int poll_err_pct = 0;
    int err_byte = -1;
    int err_step = -1;
    int byte_idx = 0;
    int got = 0;
    int reqs_seen = 0;
    int done_seen = 0;
    int done_cyc = 0;
    int mode_ack_cyc = 0;
    logic [ADDR_W-1:0] job_addr = '0;
    logic [ADDR_W-1:0] exp_next = '0;
    logic [7:0] ctrl_q = '0;
    logic [7:0] low_q = '0;

    function automatic logic [7:0] fuse_fn(logic [ADDR_W-1:0] a);
        return (a[7:0] * 8'd29) ^ {a[10:8], 5'h15} ^ 8'hA3;
    endfunction

    function automatic logic [7:0] mwrite(logic [7:0] old, logic [7:0] d, logic [7:0] m);
        return (old & ~m) | (d & m);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // side-bus register model and output monitor
    initial begin
        forever begin
            @(negedge clk);
            sb_ack = 1'b0;
            sb_err = 1'b0;
            sb_rdata = 8'h00;
            if (rdy_cnt > 0) rdy_cnt--;
            if (sb_req && !rst) begin
                reqs_seen++;
                if (lat > 0) begin
                    lat--;
                end else begin
                    logic [ADDR_W-1:0] ea;
                    lat = $urandom_range(0, 2);
                    sb_ack = 1'b1;
                    ea = job_addr + ADDR_W'(byte_idx);
                    if (sb_we) begin
                        case (step)
                            0: begin
                                chk(sb_addr == CTRL_R && sb_wdata == 8'h40 && sb_wmask == 8'hFF,
                                    "R2 first write", {sb_addr, sb_wdata, sb_wmask}, {CTRL_R, 8'h40, 8'hFF});
                                ctrl_q = mwrite(ctrl_q, sb_wdata, sb_wmask);
                            end
                            1: begin
                                chk(sb_addr == LOW_R && sb_wdata == ea[7:0] && sb_wmask == 8'hFF,
                                    "R2 low write", {sb_addr, sb_wdata, sb_wmask}, {LOW_R, ea[7:0], 8'hFF});
                                low_q = mwrite(low_q, sb_wdata, sb_wmask);
                            end
                            2: begin
                                chk(sb_addr == CTRL_R && sb_wdata == {5'd0, ea[10:8]} && sb_wmask == HIM,
                                    "R2 high write", {sb_addr, sb_wdata, sb_wmask}, {CTRL_R, 5'd0, ea[10:8], HIM});
                                ctrl_q = mwrite(ctrl_q, sb_wdata, sb_wmask);
                            end
                            3: begin
                                chk(sb_addr == CTRL_R && sb_wdata == 8'h00 && sb_wmask == MODEM,
                                    "R2 mode write", {sb_addr, sb_wdata, sb_wmask}, {CTRL_R, 8'h00, MODEM});
                                ctrl_q = mwrite(ctrl_q, sb_wdata, sb_wmask);
                                rdy_cnt = never_ready ? 1000000 : $urandom_range(0, 12);
                                mode_ack_cyc = cyc;
                            end
                            default: chk(1'b0, "R3 write during poll/read", step, 0);
                        endcase
                        if (err_step == step && err_byte == byte_idx) sb_err = 1'b1;
                        step++;
                    end else if (step == 4) begin
                        chk(sb_addr == CTRL_R, "R3 poll target", sb_addr, CTRL_R);
                        if ($urandom_range(0, 99) < poll_err_pct) begin
                            sb_err = 1'b1;
                            sb_rdata = 8'h80 | ctrl_q;   // ready bit set but errored
                        end else if (rdy_cnt == 0) begin
                            sb_rdata = ctrl_q | 8'h80;
                            step = 5;
                        end else begin
                            sb_rdata = ctrl_q & 8'h7F;
                        end
                    end else if (step == 5) begin
                        chk(sb_addr == DATA_R, "R4 data target", sb_addr, DATA_R);
                        sb_rdata = fuse_fn({ctrl_q[2:0], low_q});
                        if (err_step == 5 && err_byte == byte_idx) sb_err = 1'b1;
                        step = 0;
                        byte_idx++;
                    end else begin
                        chk(1'b0, "R2 read before writes done", step, 4);
                    end
                end
            end
            if (byte_valid) begin
                chk(byte_addr == exp_next, "R5 byte address order", byte_addr, exp_next);
                chk(byte_data == fuse_fn(exp_next), "R4 byte data", byte_data, fuse_fn(exp_next));
                exp_next++;
                got++;
            end
            if (done) begin
                done_seen++;
                done_cyc = cyc;
            end
        end
    end

    task automatic run_job(input logic [ADDR_W-1:0] a, input int n, input int exp_st,
                           input int exp_bytes, input int poke, input string tag);
        int start_cyc;
        int waited;
        step = 0; lat = 0; byte_idx = 0; got = 0; done_seen = 0; reqs_seen = 0;
        job_addr = a; exp_next = a;
        @(negedge clk);
        start_addr = a;
        count = CNT_W'(n);
        start = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        chk(status == 2'd0, {tag, " R11 status cleared on start"}, status, 0);
        waited = 0;
        while (done_seen == 0 && waited < 5000) begin
            @(negedge clk);
            waited++;
            if (poke != 0 && waited == poke) begin
                start_addr = a + 11'd300;
                count = 8'd1;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                waited++;
            end
        end
        chk(done_seen == 1, {tag, " R5 done seen"}, done_seen, 1);
        chk(status == 2'(exp_st), {tag, " status"}, status, exp_st);
        chk(got == exp_bytes, {tag, " byte count"}, got, exp_bytes);
        if (n == 0) begin
            chk(done_cyc - start_cyc == 1, "R9 zero-count latency", done_cyc - start_cyc, 1);
            chk(reqs_seen == 0, "R9 no bus request", reqs_seen, 0);
        end
        repeat (4) @(negedge clk);
        chk(!sb_req && !busy, {tag, " R7 quiet after done"}, {sb_req, busy}, 0);
        chk(status == 2'(exp_st), {tag, " R11 status held"}, status, exp_st);
        chk(got == exp_bytes && done_seen == 1, {tag, " R10 no extra bytes"}, got, exp_bytes);
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !sb_req && !done && !byte_valid && status == 2'd0, "R1 reset state",
            {busy, sb_req, done, byte_valid, status}, 0);

        // R5 directed runs across the high-address boundary and at the top
        run_job(11'h0FE, 4, 0, 4, 0, "R5 boundary");
        run_job(11'h7FE, 2, 0, 2, 0, "R5 top");
        // R9 zero count
        run_job(11'h123, 0, 0, 0, 0, "R9");
        // R10 start while busy
        run_job(11'h100, 3, 0, 3, 10, "R10");
        // R3 errored polls with ready bit set must be retried
        poll_err_pct = 60;
        run_job(11'h2A0, 3, 0, 3, 0, "R3 poll errors");
        poll_err_pct = 0;
        // R7 bus errors on each write step and on the data read
        for (int s = 0; s < 6; s++) begin
            if (s == 4) continue;
            err_step = s; err_byte = 1;
            run_job(11'h340, 3, 1, 1, 0, "R7 bus error");
        end
        err_step = -1; err_byte = -1;
        // R8 poll timeout
        never_ready = 1;
        run_job(11'h055, 2, 2, 0, 0, "R8 timeout");
        chk(done_cyc - mode_ack_cyc >= TMO - 1 && done_cyc - mode_ack_cyc <= TMO + 8,
            "R8 timeout latency", done_cyc - mode_ack_cyc, TMO);
        never_ready = 0;
        // random runs
        poll_err_pct = 20;
        for (int j = 0; j < 20; j++) begin
            logic [ADDR_W-1:0] ra;
            int rn;
            ra = ADDR_W'($urandom_range(0, 2047 - 8));
            rn = $urandom_range(1, 6);
            run_job(ra, rn, 0, rn, 0, "R5 random");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule